// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns local addresses that fall inside an outbound region into 64-bit bus addresses. It uses a table of equal-sized windows. Software sets one global size code, and every window then covers 2^k megabytes. Each window holds a lower base word, whose bit 0 marks the window as usable, and an upper base word. A global enable bit switches translation on or off as a whole.

A requester presents a local address with a one-cycle request strobe. One clock later the block returns the 64-bit result and a hit flag. The window index is the distance of the address from the region start, divided by the window size. On a hit, the result is the window's base plus the address's offset inside the window. On a miss, the local address comes back zero-extended and unchanged.

Top module: `ob_xlat`

## Requirements
- R1: After reset every register reads zero, so translation is disabled and every request misses.
- R2: Register map. Offset 0x004 bit 1 is the translation enable, and the other bits read zero. Offset 0x030 bits [2:0] hold the size code k, and the other bits read zero. Window n keeps its lower word at 0x200+8n and its upper word at 0x204+8n, both read back in full. Any other offset reads zero, and a write to it changes no register.
- R3: A window spans 2^(20+k) bytes. The window index of address A is (A - REGION_BASE) >> (20+k).
- R4: On a hit the result is {upper, lower with bits below 20+k cleared} plus ((A - REGION_BASE) mod 2^(20+k)). Bit 0 and the other low bits of the lower word never reach the result.
- R5: A window whose lower-word bit 0 is 0 gives a miss, and the result is {32'h0, A}.
- R6: An index of 32 or more, or an address below REGION_BASE, gives a miss with the result {32'h0, A}.
- R7: While the enable bit is 0 every request misses, with the result {32'h0, A}.
- R8: A result appears with xl_out_valid high exactly one clock after the request cycle. With no request, xl_out_valid is low and the result and hit flag hold their values.
- R9: A register write applies to a request made in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| xl_req | input | 1 | Translate request strobe |
| xl_addr | input | 32 | Local address to translate |
| xl_out_valid | output | 1 | Result valid, one cycle after request |
| xl_out_addr | output | 64 | Translated or passed-through address |
| xl_hit | output | 1 | 1 when the address was translated |

## Verification
Assertions check the following on every cycle:
- The one-cycle request-to-result timing and the holding of idle outputs.
- That the low 20 address bits always survive translation.
- That every miss returns the request address unchanged.
- That a disabled block never hits.
- That writes to unmapped offsets leave the global settings untouched.

The arithmetic of the mapping itself is shown only by the bench sweeps. These cover window index, base masking and in-window offset over four size codes and every window including out-of-range ones, with a mix of valid and invalid windows. The register readback formats are also shown only by the bench.

// File: rtl/ob_xlat_pkg.sv
package ob_xlat_pkg;
  localparam int unsigned REG_AW   = 12;
  localparam int unsigned DW       = 32;
  localparam int unsigned MB_SHIFT = 20;
  localparam int unsigned KW       = 3;

  localparam logic [REG_AW-1:0] OFS_CMD  = 12'h004;
  localparam logic [REG_AW-1:0] OFS_SIZE = 12'h030;
  localparam logic [REG_AW-1:0] OFS_WIN  = 12'h200;
  localparam int unsigned       EN_BIT   = 1;

  typedef struct packed {
    logic [DW-1:0] hi;
    logic [DW-1:0] lo;
  } win_t;

  // Byte mask covering the inside of one window for size code k.
  function automatic logic [DW-1:0] win_mask(input logic [KW-1:0] k);
    return (DW'(1) << (MB_SHIFT + 32'(k))) - DW'(1);
  endfunction
endpackage

// File: rtl/ob_xlat_regs.sv
module ob_xlat_regs
  import ob_xlat_pkg::*;
#(
  parameter int unsigned NUM_WIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              xlat_en,
  output logic [KW-1:0]     size_code,
  output win_t              win_o [NUM_WIN]
);
  localparam logic [REG_AW-1:0] WIN_END = OFS_WIN + REG_AW'(8 * NUM_WIN);

  logic          en_q, en_d;
  logic [KW-1:0] k_q, k_d;
  win_t          win_q [NUM_WIN];

  // Next state of the global settings.
  always_comb begin
    en_d = en_q;
    k_d  = k_q;
    if (reg_we && reg_addr == OFS_CMD)  en_d = reg_wdata[EN_BIT];
    if (reg_we && reg_addr == OFS_SIZE) k_d  = reg_wdata[KW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      k_q  <= '0;
    end else begin
      en_q <= en_d;
      k_q  <= k_d;
    end
  end

  // Window table: one clock-enabled word pair per window.
  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    logic sel_lo, sel_hi;
    assign sel_lo = reg_we && (reg_addr == OFS_WIN + REG_AW'(8 * n));
    assign sel_hi = reg_we && (reg_addr == OFS_WIN + REG_AW'(8 * n + 4));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_q[n] <= '0;
      end else begin
        if (sel_lo) win_q[n].lo <= reg_wdata;
        if (sel_hi) win_q[n].hi <= reg_wdata;
      end
    end
    assign win_o[n] = win_q[n];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CMD)  reg_rdata[EN_BIT]  = en_q;
    if (reg_addr == OFS_SIZE) reg_rdata[KW-1:0]  = k_q;
    for (int n = 0; n < NUM_WIN; n++) begin
      if (reg_addr == OFS_WIN + REG_AW'(8 * n))     reg_rdata = win_q[n].lo;
      if (reg_addr == OFS_WIN + REG_AW'(8 * n + 4)) reg_rdata = win_q[n].hi;
    end
  end

  assign xlat_en   = en_q;
  assign size_code = k_q;

  logic mapped;
  assign mapped = (reg_addr == OFS_CMD) || (reg_addr == OFS_SIZE) ||
                  ((reg_addr >= OFS_WIN) && (reg_addr < WIN_END) && (reg_addr[1:0] == 2'b00));

  // R2: writes to unmapped offsets leave the global settings alone.
  p_unmapped_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !mapped) |=> ($stable(xlat_en) && $stable(size_code)));
endmodule

// File: rtl/ob_xlat_lookup.sv
module ob_xlat_lookup
  import ob_xlat_pkg::*;
#(
  parameter int unsigned   NUM_WIN     = 32,
  parameter logic [DW-1:0] REGION_BASE = 32'h4000_0000
) (
  input  logic [DW-1:0]   addr,
  input  logic            xlat_en,
  input  logic [KW-1:0]   size_code,
  input  win_t            win_i [NUM_WIN],
  output logic            hit,
  output logic [2*DW-1:0] out_addr
);
  localparam int unsigned IDXW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [DW-1:0]   off, idx_full, mask;
  logic [IDXW-1:0] idx;
  logic            below, in_range;
  win_t            sel;
  logic [2*DW-1:0] xl;

  always_comb begin
    below    = addr < REGION_BASE;
    off      = addr - REGION_BASE;
    idx_full = off >> (MB_SHIFT + 32'(size_code));
    in_range = idx_full < DW'(NUM_WIN);
    idx      = idx_full[IDXW-1:0];
    sel      = in_range ? win_i[idx] : '0;
    mask     = win_mask(size_code);
    xl       = {sel.hi, sel.lo & ~mask} + {{DW{1'b0}}, off & mask};
    hit      = xlat_en && !below && in_range && sel.lo[0];
    out_addr = hit ? xl : {{DW{1'b0}}, addr};
  end
endmodule

// File: rtl/ob_xlat.sv
module ob_xlat
  import ob_xlat_pkg::*;
#(
  parameter int unsigned   NUM_WIN     = 32,
  parameter logic [DW-1:0] REGION_BASE = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              xl_req,
  input  logic [DW-1:0]     xl_addr,
  output logic              xl_out_valid,
  output logic [2*DW-1:0]   xl_out_addr,
  output logic              xl_hit
);
  logic          xlat_en;
  logic [KW-1:0] size_code;
  win_t          win [NUM_WIN];
  logic          lk_hit;
  logic [2*DW-1:0] lk_addr;

  ob_xlat_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xlat_en(xlat_en),
    .size_code(size_code), .win_o(win)
  );

  ob_xlat_lookup #(.NUM_WIN(NUM_WIN), .REGION_BASE(REGION_BASE)) u_lookup (
    .addr(xl_addr), .xlat_en(xlat_en), .size_code(size_code), .win_i(win),
    .hit(lk_hit), .out_addr(lk_addr)
  );

  // Result stage: next state, then register.
  logic            vld_q, vld_d, hit_q, hit_d;
  logic [2*DW-1:0] res_q, res_d;

  always_comb begin
    vld_d = xl_req;
    hit_d = hit_q;
    res_d = res_q;
    if (xl_req) begin
      hit_d = lk_hit;
      res_d = lk_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      hit_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      hit_q <= hit_d;
      res_q <= res_d;
    end
  end

  assign xl_out_valid = vld_q;
  assign xl_hit       = hit_q;
  assign xl_out_addr  = res_q;

  // R8: a request yields a result one clock later.
  p_req_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_out_valid);
  // R8: idle cycles keep valid low and outputs held.
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> (!xl_out_valid && $stable(xl_out_addr) && $stable(xl_hit)));
  // R4: the in-window low 20 bits always survive (base is MB aligned).
  p_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> (xl_out_addr[MB_SHIFT-1:0] == $past(xl_addr[MB_SHIFT-1:0])));
  // R5/R6: a miss returns the local address zero-extended.
  p_miss_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> (xl_hit || xl_out_addr == {{DW{1'b0}}, $past(xl_addr)}));
  // R7: no hit while translation is disabled.
  p_disabled_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !xlat_en) |=> !xl_hit);
endmodule

// File: tb/ob_xlat_bench.sv
module ob_xlat_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          NW         = 32;
  localparam logic [31:0] BASE       = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        xl_req;
  logic [31:0] xl_addr;
  logic        xl_out_valid, xl_hit;
  logic [63:0] xl_out_addr;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_lo [NW];
  logic [31:0] m_hi [NW];
  logic        m_en;
  logic [2:0]  m_k;

  ob_xlat #(.NUM_WIN(NW), .REGION_BASE(BASE)) u_ob_xlat (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_req(xl_req),
    .xl_addr(xl_addr), .xl_out_valid(xl_out_valid),
    .xl_out_addr(xl_out_addr), .xl_hit(xl_hit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(tag, 64'(reg_rdata), 64'(exp));
  endtask

  function automatic void model(input logic [31:0] a, output logic h, output logic [63:0] o);
    int unsigned sh;
    logic [31:0] off, idx;
    sh = 20 + int'(m_k);
    h  = 1'b0;
    o  = {32'h0, a};
    if (m_en && a >= BASE) begin
      off = a - BASE;
      idx = off >> sh;
      if (idx < NW && m_lo[idx][0]) begin
        h = 1'b1;
        o = {m_hi[idx], 32'h0} + 64'((m_lo[idx] >> sh) << sh) + 64'(off % (32'd1 << sh));
      end
    end
  endfunction

  task automatic probe(input string tag, input logic [31:0] a);
    logic        eh;
    logic [63:0] eo;
    @(negedge clk);
    xl_req = 1'b1; xl_addr = a;
    @(negedge clk);
    xl_req = 1'b0;
    model(a, eh, eo);
    check({tag, " valid"}, 64'(xl_out_valid), 64'd1);
    check({tag, " hit"},   64'(xl_hit), 64'(eh));
    check({tag, " addr"},  xl_out_addr, eo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    xl_req = 1'b0; xl_addr = '0;
    m_en = 1'b0; m_k = '0;
    for (int n = 0; n < NW; n++) begin m_lo[n] = '0; m_hi[n] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_chk("R1 cmd",  12'h004, 32'h0);
    rd_chk("R1 size", 12'h030, 32'h0);
    rd_chk("R1 lo0",  12'h200, 32'h0);
    rd_chk("R1 hi31", 12'h2FC, 32'h0);
    probe("R1 miss after reset", BASE);

    // Program windows: every fifth starting at 3 is invalid; low bits carry junk.
    for (int n = 0; n < NW; n++) begin
      m_lo[n] = (32'h9000_0000 + 32'(n) * 32'h0813_57F0) | 32'((n % 5) != 3);
      m_hi[n] = 32'h100 + 32'(n) * 3;
      wr(12'(12'h200 + 8 * n), m_lo[n]);
      wr(12'(12'h204 + 8 * n), m_hi[n]);
    end

    // R2: register map
    rd_chk("R2 lo7",  12'h238, m_lo[7]);
    rd_chk("R2 hi7",  12'h23C, m_hi[7]);
    rd_chk("R2 lo31", 12'h2F8, m_lo[31]);
    wr(12'h030, 32'hFFFF_FFFD); m_k = 3'd5;
    rd_chk("R2 size", 12'h030, 32'h5);
    wr(12'h004, 32'hFFFF_FFFD); m_en = 1'b0;
    rd_chk("R2 cmd bit1 clear", 12'h004, 32'h0);
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h201, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped write cmd", 12'h004, 32'h0);
    rd_chk("R2 unmapped write size", 12'h030, 32'h5);
    rd_chk("R2 unmapped read", 12'h100, 32'h0);
    rd_chk("R2 misaligned read", 12'h201, 32'h0);
    rd_chk("R2 lo0 intact", 12'h200, m_lo[0]);

    // R7: disabled
    for (int n = 0; n < 6; n++) probe("R7 disabled", BASE + 32'(n) * 32'h0040_0123);

    wr(12'h004, 32'h0000_0002); m_en = 1'b1;
    rd_chk("R2 cmd", 12'h004, 32'h2);

    // R3..R6 sweep over size codes and windows
    for (int ki = 0; ki < 4; ki++) begin
      logic [2:0] k;
      k = (ki == 0) ? 3'd0 : (ki == 1) ? 3'd1 : (ki == 2) ? 3'd3 : 3'd7;
      wr(12'h030, 32'(k)); m_k = k;
      for (int n = 0; n < NW + 4; n++) begin
        for (int j = 0; j < 3; j++) begin
          logic [63:0] a64, wsz, inw;
          logic [31:0] idx;
          string tag;
          wsz = 64'd1 << (20 + int'(k));
          inw = (j == 0) ? 64'd0 : (j == 1) ? wsz - 1 : ((64'(n) * 64'h0001_3579) % wsz);
          a64 = 64'(BASE) + 64'(n) * wsz + inw;
          if (a64 < 64'h1_0000_0000) begin
            idx = 32'(n);
            tag = (idx >= NW) ? "R6 index range" : ((n % 5) == 3) ? "R5 invalid window" : "R3/R4 hit";
            probe(tag, a64[31:0]);
          end
        end
      end
    end

    // R6: below region
    probe("R6 below base", BASE - 32'd1);
    probe("R6 zero address", 32'h0);

    // R8: idle hold
    probe("R8 hit before idle", BASE + 32'h0000_1234);
    held = xl_out_addr;
    repeat (3) @(negedge clk);
    check("R8 idle valid low", 64'(xl_out_valid), 64'd0);
    check("R8 idle addr hold", xl_out_addr, held);

    // R9: write followed at once by a request
    wr(12'h030, 32'h0); m_k = 3'd0;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'h208; reg_wdata = 32'hABC0_0001;
    @(negedge clk);
    reg_we = 1'b0; m_lo[1] = 32'hABC0_0001;
    xl_req = 1'b1; xl_addr = BASE + 32'h0010_0042;
    @(negedge clk);
    xl_req = 1'b0;
    check("R9 hit", 64'(xl_hit), 64'd1);
    check("R9 addr", xl_out_addr, {m_hi[1], 32'hABC0_0042});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule